// File: doc/BRIEF.md
# Serial Run-Length Stress Classifier

This block watches a serial bit stream after line coding and measures how long the line stays at one level. For every bit accepted on the bit-rate enable it extends or restarts the current run, remembers the longest run seen since the last clear, and reports the level of the run in progress. A test setup uses it to prove that a stress field really drove the serial link into its worst low-frequency condition on at least some lines, and for how many bits that condition lasted.

Two repeating shapes are recognised. The first is the equalizer shape: a run of 19 bits at one level followed by a single bit of the other level, over and over. Either level may carry the long run, and that level is reported. The second is the loop-lock shape: runs of exactly 20 bits that alternate between the two levels. A flag rises only after a shape has repeated for four whole periods. It falls on the bit where a run breaks the expected length. Ordinary picture data, which can hold the line for up to 26 bits, never raises a flag.

A classifier state machine acts on two events from the run tracker. A "run done" event carries the length and level of a run that a level change has just closed. A "grow" event carries the length of the current run after the bit is added. The four states are `ST_HUNT` (no shape), `ST_EQ_GOT_LONG` (19-run closed, a 1-run is expected), `ST_EQ_GOT_SHORT` (1-run closed, a 19-run is expected) and `ST_PLL_RUN` (20-run closed, another 20-run is expected). From any state, a closed run of 19 enters `ST_EQ_GOT_LONG` with a zero period count, and a closed run of 20 enters `ST_PLL_RUN` with a count of one. Any other closed run that does not fit returns to `ST_HUNT`. `ST_EQ_GOT_LONG` moves to `ST_EQ_GOT_SHORT` when a 1-run closes, and this adds one period. `ST_EQ_GOT_SHORT` moves back to `ST_EQ_GOT_LONG` when a 19-run closes. `ST_PLL_RUN` stays where it is and adds one per closed 20-run. In each tracking state, a growing run that passes the expected length sends the machine to `ST_HUNT`.

Top module: `serial_stress_classifier`

## Requirements
- R1: After reset, run_len, run_max, lock_bits, eq_lock and pll_lock are all zero.
- R2: On each cycle with bit_en high, a bit equal to run_level adds one to run_len, and a differing bit restarts run_len at 1 with run_level set to that bit. With bit_en low, run_len, run_level and run_max do not change.
- R3: run_len saturates at 63 and stays at 63 while the level holds.
- R4: run_max holds the largest run_len value reached since the last clear. A clear sets run_max and lock_bits to zero and leaves run_len unchanged.
- R5: eq_lock rises on the first bit after the fourth 1-bit run in a sequence that starts with a 19-bit run, and it is low before that bit.
- R6: While eq_lock is high, eq_pol equals the level of the 19-bit runs, for both levels.
- R7: pll_lock rises on the first bit after the eighth consecutive closed 20-bit run of alternating level, and it is low after seven such runs.
- R8: A lock flag falls on the bit where the growing run exceeds its expected length, or on the bit that closes a run of the wrong length. The two flags are never high together.
- R9: Alternating runs of 26 bits, the 21/1 shape and the 19/2 shape never raise either flag.
- R10: lock_bits adds one for each enabled bit that arrives while a flag is already high, and it saturates at its maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Bit-rate enable; bit_in is taken on cycles where it is high |
| bit_in | input | 1 | Serial line level |
| clear | input | 1 | Zeroes run_max and lock_bits |
| run_len | output | 6 | Length of the current run, saturating |
| run_level | output | 1 | Level of the current run |
| run_max | output | 6 | Longest run since the last clear |
| eq_lock | output | 1 | Equalizer shape locked |
| eq_pol | output | 1 | Level of the 19-bit runs |
| pll_lock | output | 1 | Loop-lock shape locked |
| lock_bits | output | 16 | Bits received while locked, saturating |

## Verification
On every cycle the assertions check the run counter's restart and saturation, that every output holds when the enable is low, the effect of clear, that run_max never falls below the current run, that the lock counter steps while a flag is high, that the two flags are never high together, and that a flag only rises on the first bit of a new run. Only the bench scenarios can show the exact bit on which each flag rises and falls, the polarity reported for both levels, and that the near-miss shapes and 26-bit runs are never flagged. Those outcomes depend on whole sequences of runs rather than on a single cycle.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
    typedef enum logic [1:0] {
        ST_HUNT,
        ST_EQ_GOT_LONG,
        ST_EQ_GOT_SHORT,
        ST_PLL_RUN
    } cls_state_t;
endpackage

// File: rtl/ssc_run_tracker.sv
module ssc_run_tracker #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             bit_in,
    input  logic             clear,
    output logic [CNT_W-1:0] run_len,
    output logic             run_level,
    output logic [CNT_W-1:0] run_max,
    output logic             done_vld,
    output logic [CNT_W-1:0] done_len,
    output logic             done_lvl,
    output logic             grow_vld,
    output logic [CNT_W-1:0] next_len
);
    localparam logic [CNT_W-1:0] CAP = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    // Close the current run when the level changes on a started run
    always_comb begin
        done_vld = bit_en && (run_len != '0) && (bit_in != run_level);
        grow_vld = bit_en && !done_vld;
        done_len = run_len;
        done_lvl = run_level;
        if (done_vld)
            next_len = ONE;
        else if (run_len == CAP)
            next_len = CAP;
        else
            next_len = run_len + ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len   <= '0;
            run_level <= 1'b0;
        end else if (bit_en) begin
            run_len   <= next_len;
            run_level <= bit_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            run_max <= '0;
        else if (clear)
            run_max <= '0;
        else if (bit_en && (next_len > run_max))
            run_max <= next_len;
    end
endmodule

// File: rtl/ssc_stress_fsm.sv
module ssc_stress_fsm
    import ssc_pkg::*;
#(
    parameter int CNT_W        = 6,
    parameter int EQ_LONG_LEN  = 19,
    parameter int PLL_LEN      = 20,
    parameter int LOCK_PERIODS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done_vld,
    input  logic [CNT_W-1:0] done_len,
    input  logic             done_lvl,
    input  logic             grow_vld,
    input  logic [CNT_W-1:0] next_len,
    output logic             eq_lock,
    output logic             eq_pol,
    output logic             pll_lock
);
    localparam int REP_MAX = 2 * LOCK_PERIODS;
    localparam int REP_W   = $clog2(REP_MAX + 1);
    localparam logic [CNT_W-1:0] LEN_EQ_LONG  = CNT_W'(EQ_LONG_LEN);
    localparam logic [CNT_W-1:0] LEN_EQ_SHORT = CNT_W'(1);
    localparam logic [CNT_W-1:0] LEN_PLL      = CNT_W'(PLL_LEN);
    localparam logic [REP_W-1:0] REP_TOP      = REP_W'(REP_MAX);
    localparam logic [REP_W-1:0] REP_EQ_LOCK  = REP_W'(LOCK_PERIODS);
    localparam logic [REP_W-1:0] REP_ONE      = REP_W'(1);

    cls_state_t       state, state_nx;
    logic [REP_W-1:0] reps, reps_nx, reps_inc;
    logic             pol, pol_nx;
    cls_state_t       fresh_state;
    logic [REP_W-1:0] fresh_reps;

    // Entry decision for a closed run that does not continue a shape
    always_comb begin
        reps_inc = (reps == REP_TOP) ? REP_TOP : reps + REP_ONE;
        if (done_len == LEN_EQ_LONG) begin
            fresh_state = ST_EQ_GOT_LONG;
            fresh_reps  = '0;
        end else if (done_len == LEN_PLL) begin
            fresh_state = ST_PLL_RUN;
            fresh_reps  = REP_ONE;
        end else begin
            fresh_state = ST_HUNT;
            fresh_reps  = '0;
        end
    end

    always_comb begin
        state_nx = state;
        reps_nx  = reps;
        pol_nx   = pol;
        unique case (state)
            ST_HUNT: begin
                if (done_vld) begin
                    state_nx = fresh_state;
                    reps_nx  = fresh_reps;
                    pol_nx   = done_lvl;
                end
            end
            ST_EQ_GOT_LONG: begin
                if (done_vld) begin
                    if (done_len == LEN_EQ_SHORT) begin
                        state_nx = ST_EQ_GOT_SHORT;
                        reps_nx  = reps_inc;
                    end else begin
                        state_nx = fresh_state;
                        reps_nx  = fresh_reps;
                        pol_nx   = done_lvl;
                    end
                end else if (grow_vld && (next_len > LEN_EQ_SHORT)) begin
                    state_nx = ST_HUNT;
                    reps_nx  = '0;
                end
            end
            ST_EQ_GOT_SHORT: begin
                if (done_vld) begin
                    if (done_len == LEN_EQ_LONG) begin
                        state_nx = ST_EQ_GOT_LONG;
                    end else begin
                        state_nx = fresh_state;
                        reps_nx  = fresh_reps;
                        pol_nx   = done_lvl;
                    end
                end else if (grow_vld && (next_len > LEN_EQ_LONG)) begin
                    state_nx = ST_HUNT;
                    reps_nx  = '0;
                end
            end
            ST_PLL_RUN: begin
                if (done_vld) begin
                    if (done_len == LEN_PLL) begin
                        reps_nx = reps_inc;
                    end else begin
                        state_nx = fresh_state;
                        reps_nx  = fresh_reps;
                        pol_nx   = done_lvl;
                    end
                end else if (grow_vld && (next_len > LEN_PLL)) begin
                    state_nx = ST_HUNT;
                    reps_nx  = '0;
                end
            end
            default: begin
                state_nx = ST_HUNT;
                reps_nx  = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_HUNT;
            reps  <= '0;
            pol   <= 1'b0;
        end else begin
            state <= state_nx;
            reps  <= reps_nx;
            pol   <= pol_nx;
        end
    end

    always_comb begin
        eq_lock  = ((state == ST_EQ_GOT_LONG) || (state == ST_EQ_GOT_SHORT))
                   && (reps >= REP_EQ_LOCK);
        pll_lock = (state == ST_PLL_RUN) && (reps >= REP_TOP);
        eq_pol   = pol;
    end
endmodule

// File: rtl/ssc_lock_timer.sv
module ssc_lock_timer #(
    parameter int LB_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bit_en,
    input  logic            active,
    input  logic            clear,
    output logic [LB_W-1:0] lock_bits
);
    localparam logic [LB_W-1:0] TOP = {LB_W{1'b1}};
    localparam logic [LB_W-1:0] ONE = {{(LB_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            lock_bits <= '0;
        else if (clear)
            lock_bits <= '0;
        else if (bit_en && active && (lock_bits != TOP))
            lock_bits <= lock_bits + ONE;
    end
endmodule

// File: rtl/serial_stress_classifier.sv
module serial_stress_classifier #(
    parameter int CNT_W        = 6,
    parameter int LB_W         = 16,
    parameter int EQ_LONG_LEN  = 19,
    parameter int PLL_LEN      = 20,
    parameter int LOCK_PERIODS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             bit_in,
    input  logic             clear,
    output logic [CNT_W-1:0] run_len,
    output logic             run_level,
    output logic [CNT_W-1:0] run_max,
    output logic             eq_lock,
    output logic             eq_pol,
    output logic             pll_lock,
    output logic [LB_W-1:0]  lock_bits
);
    logic             done_vld, done_lvl, grow_vld;
    logic [CNT_W-1:0] done_len, next_len;

    ssc_run_tracker #(.CNT_W(CNT_W)) tracker_i (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .clear(clear), .run_len(run_len), .run_level(run_level),
        .run_max(run_max), .done_vld(done_vld), .done_len(done_len),
        .done_lvl(done_lvl), .grow_vld(grow_vld), .next_len(next_len)
    );

    ssc_stress_fsm #(
        .CNT_W(CNT_W), .EQ_LONG_LEN(EQ_LONG_LEN),
        .PLL_LEN(PLL_LEN), .LOCK_PERIODS(LOCK_PERIODS)
    ) fsm_i (
        .clk(clk), .rst_n(rst_n), .done_vld(done_vld),
        .done_len(done_len), .done_lvl(done_lvl), .grow_vld(grow_vld),
        .next_len(next_len), .eq_lock(eq_lock), .eq_pol(eq_pol),
        .pll_lock(pll_lock)
    );

    ssc_lock_timer #(.LB_W(LB_W)) timer_i (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
        .active(eq_lock || pll_lock), .clear(clear),
        .lock_bits(lock_bits)
    );
endmodule

// File: rtl/ssc_checker.sv
module ssc_checker #(
    parameter int CNT_W = 6,
    parameter int LB_W  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_en,
    input logic             bit_in,
    input logic             clear,
    input logic [CNT_W-1:0] run_len,
    input logic             run_level,
    input logic [CNT_W-1:0] run_max,
    input logic             eq_lock,
    input logic             pll_lock,
    input logic [LB_W-1:0]  lock_bits
);
    localparam logic [CNT_W-1:0] CAP   = {CNT_W{1'b1}};
    localparam logic [LB_W-1:0]  LBTOP = {LB_W{1'b1}};

    assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && run_len != '0 && bit_in != run_level) |=> (run_len == 1));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_en && !clear) |=> ($stable(run_len) && $stable(run_level)
                                 && $stable(run_max) && $stable(lock_bits)));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && bit_in == run_level && run_len == CAP) |=> (run_len == CAP));

    assert_clear_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (run_max == '0 && lock_bits == '0));

    assert_max_covers_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !clear) |=> (run_max >= run_len));

    assert_eq_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eq_lock) |-> (run_len == 1));

    assert_pll_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_lock) |-> (run_len == 1));

    assert_one_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(eq_lock && pll_lock));

    assert_lock_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && (eq_lock || pll_lock) && !clear && lock_bits != LBTOP)
        |=> (lock_bits == $past(lock_bits) + 1'b1));
endmodule

bind serial_stress_classifier ssc_checker #(.CNT_W(CNT_W), .LB_W(LB_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
    .clear(clear), .run_len(run_len), .run_level(run_level),
    .run_max(run_max), .eq_lock(eq_lock), .pll_lock(pll_lock),
    .lock_bits(lock_bits)
);

// File: tb/serial_stress_classifier_tb_top.sv
module serial_stress_classifier_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic        bit_in = 1'b0;
    logic        clear = 1'b0;
    logic [5:0]  run_len, run_max;
    logic        run_level, eq_lock, eq_pol, pll_lock;
    logic [15:0] lock_bits;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    serial_stress_classifier dut_i (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .clear(clear), .run_len(run_len), .run_level(run_level),
        .run_max(run_max), .eq_lock(eq_lock), .eq_pol(eq_pol),
        .pll_lock(pll_lock), .lock_bits(lock_bits)
    );

    task automatic check(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bit_en = 1'b0; clear = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic send_run(bit lvl, int n);
        for (int i = 0; i < n; i++) begin
            bit_en = 1'b1; bit_in = lvl;
            @(negedge clk);
            bit_en = 1'b0;
        end
    endtask

    task automatic t_reset();
        do_reset();
        check("R1", "run_len", run_len, 0);
        check("R1", "run_max", run_max, 0);
        check("R1", "lock_bits", lock_bits, 0);
        check("R1", "eq_lock", eq_lock, 0);
        check("R1", "pll_lock", pll_lock, 0);
    endtask

    task automatic t_runs();
        do_reset();
        send_run(1, 3);
        check("R2", "run_len after 3 ones", run_len, 3);
        check("R2", "run_level", run_level, 1);
        send_run(0, 1);
        check("R2", "run_len restart", run_len, 1);
        check("R2", "run_level after change", run_level, 0);
        repeat (4) @(negedge clk);
        check("R2", "run_len idle", run_len, 1);
        check("R4", "run_max held", run_max, 3);
        send_run(0, 70);
        check("R3", "run_len saturated", run_len, 63);
        check("R3", "run_max saturated", run_max, 63);
        clear = 1'b1; @(negedge clk); clear = 1'b0;
        check("R4", "run_max cleared", run_max, 0);
        check("R4", "run_len kept by clear", run_len, 63);
        send_run(1, 1);
        check("R4", "run_max after clear", run_max, 1);
    endtask

    task automatic t_eq(bit p, bit full);
        do_reset();
        send_run(p, 19);
        for (int k = 0; k < 3; k++) begin
            send_run(!p, 1);
            send_run(p, 19);
        end
        check("R5", "eq_lock after 3 periods", eq_lock, 0);
        send_run(!p, 1);
        send_run(p, 1);
        check("R5", "eq_lock after 4 periods", eq_lock, 1);
        check("R6", "eq_pol", eq_pol, p);
        check("R8", "pll_lock while eq", pll_lock, 0);
        if (full) begin
            send_run(p, 18);
            send_run(!p, 1);
            send_run(p, 1);
            check("R5", "eq_lock held", eq_lock, 1);
            check("R10", "lock_bits in lock", lock_bits, 20);
            send_run(p, 18);
            check("R8", "eq_lock at 19", eq_lock, 1);
            send_run(p, 1);
            check("R8", "eq_lock after long run too long", eq_lock, 0);
            check("R10", "lock_bits after break", lock_bits, 39);
            send_run(p, 1);
            check("R10", "lock_bits frozen", lock_bits, 39);
            clear = 1'b1; @(negedge clk); clear = 1'b0;
            check("R4", "lock_bits cleared", lock_bits, 0);
        end
    endtask

    task automatic t_pll();
        bit l;
        do_reset();
        l = 1'b1;
        for (int k = 0; k < 7; k++) begin
            send_run(l, 20);
            l = !l;
        end
        send_run(l, 1);
        check("R7", "pll_lock after 7 runs", pll_lock, 0);
        send_run(l, 19);
        send_run(!l, 1);
        check("R7", "pll_lock after 8 runs", pll_lock, 1);
        check("R8", "eq_lock while pll", eq_lock, 0);
        send_run(!l, 18);
        check("R8", "pll_lock at 19 of short run", pll_lock, 1);
        send_run(l, 1);
        check("R8", "pll_lock after run of 19 closed", pll_lock, 0);
    endtask

    task automatic t_near_miss();
        do_reset();
        for (int k = 0; k < 8; k++) send_run(k % 2, 26);
        send_run(0, 1);
        check("R9", "26-run eq_lock", eq_lock, 0);
        check("R9", "26-run pll_lock", pll_lock, 0);
        check("R9", "26-run run_max", run_max, 26);
        for (int k = 0; k < 8; k++) begin
            send_run(1, 21);
            send_run(0, 1);
        end
        send_run(1, 1);
        check("R9", "21/1 eq_lock", eq_lock, 0);
        for (int k = 0; k < 8; k++) begin
            send_run(1, 19);
            send_run(0, 2);
        end
        send_run(1, 1);
        check("R9", "19/2 eq_lock", eq_lock, 0);
        check("R9", "19/2 pll_lock", pll_lock, 0);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: act=%0d exp=%0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        t_reset();
        t_runs();
        t_eq(1'b1, 1'b1);
        t_eq(1'b0, 1'b0);
        t_pll();
        t_near_miss();
        finished = 1'b1;
        summary();
        $finish;
    end
endmodule